// File: doc/BRIEF.md
# Two-Stage Minimal RISC Core

This block is a small in-order processor core with two pipeline stages. The first stage fetches a 31-bit instruction word from a private instruction memory. The second stage decodes and executes the word, then writes its result back to a 512-entry register file or to a 512-entry data memory. Every instruction names three 9-bit fields: a destination (or jump target) field, a first source field and a second source field. The first source field also serves as an immediate value and as a direct data address. Zero and negative flags live in the core, and only a compare writes them. Jumps take their target from the destination field and can be unconditional or gated by one of the two flags.

Program words are loaded through a write port into instruction memory, normally while reset is held. After reset is released, the core runs from address 0. Debug outputs expose the program counter and both flags, and a debug address input reads any register. The core does not predict branches. A jump that is taken discards the word fetched behind it, which costs one bubble cycle. A conditional jump that is not taken costs nothing.

Top module: `rcore_top`

## Requirements
- R1: While `rst` is high at a rising edge, the PC, both flags and the pipeline-valid state clear to zero, and instruction memory still accepts writes. After release, the word at address 0 is fetched first and the PC reads 1 after one edge.
- R2: The word is {opcode[30:27], D[26:18], F1[17:9], F2[8:0]}. Opcodes 0, 1, 2, 5 and 6 write R[D] with R[F1] AND, OR, XOR, plus and minus R[F2] respectively, on 16-bit data with wrap-around.
- R3: Opcode 3 writes R[D] with the bitwise inverse of R[F1]. The F2 field has no effect on the result.
- R4: Opcode 4 (compare) sets Z when R[F1] equals R[F2] and sets N when R[F1] is less than R[F2] as signed 16-bit values. Otherwise it clears each flag. It writes no register.
- R5: No opcode other than 4 changes Z or N.
- R6: Opcode 8 stores R[D] at data address F1. Opcode 7 loads R[D] from data address F1.
- R7: Opcode 12 writes R[D] with the 9-bit F1 field, zero-extended to 16 bits.
- R8: Opcode 9 always loads the PC with D. Opcode 10 does so when N is 1, and opcode 11 when Z is 1. The target word executes two edges after the jump executes.
- R9: The word fetched behind a taken jump is discarded and changes no register, flag or memory.
- R10: A conditional jump that is not taken leaves the PC advancing by one per cycle, with no bubble.
- R11: Opcodes 13 to 15 change no register, flag or memory.
- R12: An instruction sees the result of the instruction just before it, with no stall, in both the register file and data memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_we | input | 1 | Instruction memory write enable |
| imem_waddr | input | 9 | Instruction memory write address |
| imem_wdata | input | 31 | Instruction word to write |
| dbg_reg_addr | input | 9 | Register index for debug read |
| dbg_reg_data | output | 16 | Register content at `dbg_reg_addr` |
| dbg_pc | output | 9 | Current fetch address |
| dbg_flag_z | output | 1 | Zero flag |
| dbg_flag_n | output | 1 | Negative flag |

## Verification
The program compares a negative difference against a positive value. A core that compares without sign would leave N clear, and the taken negative-flag jump would then fall through into the words after it. Writes placed right behind two taken jumps would overwrite known registers if the flush were missing. The PC is traced edge by edge across an untaken jump, so a core that stalls on it shows up. The program also includes an overflowing add, an inverse with a nonzero F2 field, a maximum immediate, a store followed at once by a load, and a no-operation code whose D field points at a live register. These expose wrong wrap, wrong field use, sign extension, a missing bypass and stray writes.

// File: rtl/rcore_pkg.sv
package rcore_pkg;

    localparam int DATA_W  = 16;
    localparam int FIELD_W = 9;
    localparam int OPC_W   = 4;
    localparam int INSTR_W = OPC_W + 3 * FIELD_W;

    typedef enum logic [OPC_W-1:0] {
        OP_AND = 4'd0,
        OP_OR  = 4'd1,
        OP_XOR = 4'd2,
        OP_NOT = 4'd3,
        OP_CMP = 4'd4,
        OP_ADD = 4'd5,
        OP_SUB = 4'd6,
        OP_LD  = 4'd7,
        OP_ST  = 4'd8,
        OP_J   = 4'd9,
        OP_JN  = 4'd10,
        OP_JZ  = 4'd11,
        OP_LRI = 4'd12
    } opcode_e;

    typedef struct packed {
        opcode_e              op;
        logic [FIELD_W-1:0]   d;
        logic [FIELD_W-1:0]   f1;
        logic [FIELD_W-1:0]   f2;
    } instr_t;

    typedef struct packed {
        logic [FIELD_W-1:0]   pc;
        instr_t               ir;
        logic                 valid;
        logic                 z;
        logic                 n;
    } core_state_t;

endpackage

// File: rtl/rcore_ram.sv
module rcore_ram #(
    parameter int WIDTH  = 16,
    parameter int ADDR_W = 9,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WIDTH-1:0]  rdata
);

    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Asynchronous read: the value written at an edge is visible right after it.
    assign rdata = mem_q[raddr];

endmodule

// File: rtl/rcore_regfile.sv
module rcore_regfile #(
    parameter int WIDTH  = 16,
    parameter int ADDR_W = 9,
    parameter int N_RD   = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic                         clk,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            waddr,
    input  logic [WIDTH-1:0]             wdata,
    input  logic [N_RD-1:0][ADDR_W-1:0]  raddr,
    output logic [N_RD-1:0][WIDTH-1:0]   rdata
);

    logic [WIDTH-1:0] regs_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            regs_q[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        assign rdata[p] = regs_q[raddr[p]];
    end

endmodule

// File: rtl/rcore_alu.sv
module rcore_alu
    import rcore_pkg::*;
#(
    parameter int  WIDTH      = 16,
    parameter int  IMM_W      = 9,
    parameter bit  SIGNED_CMP = 1'b1
) (
    input  opcode_e            op,
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    input  logic [IMM_W-1:0]   imm,
    input  logic [WIDTH-1:0]   mem_rd,
    output logic [WIDTH-1:0]   result,
    output logic               wr_reg,
    output logic               eq,
    output logic               lt
);

    always_comb begin
        result = '0;
        wr_reg = 1'b0;
        case (op)
            OP_AND: begin result = a & b;          wr_reg = 1'b1; end
            OP_OR:  begin result = a | b;          wr_reg = 1'b1; end
            OP_XOR: begin result = a ^ b;          wr_reg = 1'b1; end
            OP_NOT: begin result = ~a;             wr_reg = 1'b1; end
            OP_ADD: begin result = a + b;          wr_reg = 1'b1; end
            OP_SUB: begin result = a - b;          wr_reg = 1'b1; end
            OP_LD:  begin result = mem_rd;         wr_reg = 1'b1; end
            OP_LRI: begin result = WIDTH'(imm);    wr_reg = 1'b1; end
            default: begin result = '0;            wr_reg = 1'b0; end
        endcase
    end

    assign eq = (a == b);

    if (SIGNED_CMP) begin : g_scmp
        assign lt = $signed(a) < $signed(b);
    end else begin : g_ucmp
        assign lt = a < b;
    end

endmodule

// File: rtl/rcore_top.sv
module rcore_top
    import rcore_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               imem_we,
    input  logic [FIELD_W-1:0] imem_waddr,
    input  logic [INSTR_W-1:0] imem_wdata,
    input  logic [FIELD_W-1:0] dbg_reg_addr,
    output logic [DATA_W-1:0]  dbg_reg_data,
    output logic [FIELD_W-1:0] dbg_pc,
    output logic               dbg_flag_z,
    output logic               dbg_flag_n
);

    localparam int N_RD   = 4;
    localparam int RP_F1  = 0;
    localparam int RP_F2  = 1;
    localparam int RP_D   = 2;
    localparam int RP_DBG = 3;

    core_state_t state_d, state_q;

    instr_t                          ex;
    logic [INSTR_W-1:0]              imem_rdata;
    logic [N_RD-1:0][FIELD_W-1:0]    rf_raddr;
    logic [N_RD-1:0][DATA_W-1:0]     rf_rdata;
    logic [DATA_W-1:0]               dm_rdata;
    logic [DATA_W-1:0]               alu_res;
    logic                            alu_wr;
    logic                            alu_eq;
    logic                            alu_lt;
    logic                            rf_we;
    logic                            dm_we;
    logic                            jump_taken;

    // Signals watched by the bound checker.
    logic                            ex_valid;
    opcode_e                         ex_op;
    logic [FIELD_W-1:0]              ex_tgt;

    assign ex       = state_q.ir;
    assign ex_valid = state_q.valid;
    assign ex_op    = state_q.ir.op;
    assign ex_tgt   = state_q.ir.d;

    rcore_ram #(
        .WIDTH  (INSTR_W),
        .ADDR_W (FIELD_W)
    ) u_imem (
        .clk   (clk),
        .we    (imem_we),
        .waddr (imem_waddr),
        .wdata (imem_wdata),
        .raddr (state_q.pc),
        .rdata (imem_rdata)
    );

    assign rf_raddr[RP_F1]  = ex.f1;
    assign rf_raddr[RP_F2]  = ex.f2;
    assign rf_raddr[RP_D]   = ex.d;
    assign rf_raddr[RP_DBG] = dbg_reg_addr;

    rcore_regfile #(
        .WIDTH  (DATA_W),
        .ADDR_W (FIELD_W),
        .N_RD   (N_RD)
    ) u_rf (
        .clk   (clk),
        .we    (rf_we),
        .waddr (ex.d),
        .wdata (alu_res),
        .raddr (rf_raddr),
        .rdata (rf_rdata)
    );

    rcore_ram #(
        .WIDTH  (DATA_W),
        .ADDR_W (FIELD_W)
    ) u_dmem (
        .clk   (clk),
        .we    (dm_we),
        .waddr (ex.f1),
        .wdata (rf_rdata[RP_D]),
        .raddr (ex.f1),
        .rdata (dm_rdata)
    );

    rcore_alu #(
        .WIDTH      (DATA_W),
        .IMM_W      (FIELD_W),
        .SIGNED_CMP (1'b1)
    ) u_alu (
        .op     (ex.op),
        .a      (rf_rdata[RP_F1]),
        .b      (rf_rdata[RP_F2]),
        .imm    (ex.f1),
        .mem_rd (dm_rdata),
        .result (alu_res),
        .wr_reg (alu_wr),
        .eq     (alu_eq),
        .lt     (alu_lt)
    );

    always_comb begin
        state_d    = state_q;
        rf_we      = 1'b0;
        dm_we      = 1'b0;
        jump_taken = 1'b0;

        // Execute stage
        if (state_q.valid) begin
            rf_we = alu_wr;
            case (ex.op)
                OP_CMP: begin
                    state_d.z = alu_eq;
                    state_d.n = alu_lt;
                end
                OP_ST: dm_we      = 1'b1;
                OP_J:  jump_taken = 1'b1;
                OP_JN: jump_taken = state_q.n;
                OP_JZ: jump_taken = state_q.z;
                default: ;
            endcase
        end

        // Fetch stage: redirect and flush on a taken jump
        if (jump_taken) begin
            state_d.pc    = ex.d;
            state_d.valid = 1'b0;
            state_d.ir    = '0;
        end else begin
            state_d.pc    = state_q.pc + FIELD_W'(1);
            state_d.valid = 1'b1;
            state_d.ir    = instr_t'(imem_rdata);
        end

        if (rst) begin
            state_d = '0;
            rf_we   = 1'b0;
            dm_we   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign dbg_reg_data = rf_rdata[RP_DBG];
    assign dbg_pc       = state_q.pc;
    assign dbg_flag_z   = state_q.z;
    assign dbg_flag_n   = state_q.n;

endmodule

// File: rtl/rcore_chk.sv
module rcore_chk
    import rcore_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [FIELD_W-1:0] pc,
    input logic               z,
    input logic               n,
    input logic               ex_valid,
    input opcode_e            ex_op,
    input logic [FIELD_W-1:0] ex_tgt
);

    // R1: reset clears PC, flags and the pipeline valid bit
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (pc == '0) && !z && !n && !ex_valid);

    // R5: flags hold unless a compare executes
    p_flags_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !(ex_valid && ex_op == OP_CMP) |=> $stable({z, n}));

    // R8: unconditional jump redirects the PC
    p_jump_target_r8: assert property (@(posedge clk) disable iff (rst)
        (ex_valid && ex_op == OP_J) |=> (pc == $past(ex_tgt)));

    // R8: negative-flag jump taken when N is set
    p_jn_taken_r8: assert property (@(posedge clk) disable iff (rst)
        (ex_valid && ex_op == OP_JN && n) |=> (pc == $past(ex_tgt)));

    // R8: zero-flag jump taken when Z is set
    p_jz_taken_r8: assert property (@(posedge clk) disable iff (rst)
        (ex_valid && ex_op == OP_JZ && z) |=> (pc == $past(ex_tgt)));

    // R9: a taken jump leaves a bubble in execute
    p_flush_bubble_r9: assert property (@(posedge clk) disable iff (rst)
        (ex_valid && (ex_op == OP_J || (ex_op == OP_JN && n) || (ex_op == OP_JZ && z)))
        |=> !ex_valid);

    // R10: with no taken jump the PC advances by one
    p_seq_fetch_r10: assert property (@(posedge clk) disable iff (rst)
        !(ex_valid && (ex_op == OP_J || (ex_op == OP_JN && n) || (ex_op == OP_JZ && z)))
        |=> (pc == FIELD_W'($past(pc) + FIELD_W'(1))) && ex_valid);

endmodule

bind rcore_top rcore_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .pc       (dbg_pc),
    .z        (dbg_flag_z),
    .n        (dbg_flag_n),
    .ex_valid (ex_valid),
    .ex_op    (ex_op),
    .ex_tgt   (ex_tgt)
);

// File: tb/rcore_top_tb_top.sv
`timescale 1ns/1ps
module rcore_top_tb_top;

    localparam int NPROG = 23;
    localparam int NREG  = 12;

    // Program: {opcode[30:27], D[26:18], F1[17:9], F2[8:0]}
    localparam logic [30:0] PROG [NPROG] = '{
        {4'd12, 9'd1,  9'd100, 9'd0},  // 0  LRI r1,100
        {4'd12, 9'd2,  9'd37,  9'd0},  // 1  LRI r2,37
        {4'd0,  9'd3,  9'd1,   9'd2},  // 2  AND r3
        {4'd1,  9'd4,  9'd1,   9'd2},  // 3  OR r4
        {4'd2,  9'd5,  9'd1,   9'd2},  // 4  XOR r5
        {4'd3,  9'd6,  9'd1,   9'd0},  // 5  NOT r6
        {4'd5,  9'd7,  9'd1,   9'd2},  // 6  ADD r7
        {4'd6,  9'd8,  9'd2,   9'd1},  // 7  SUB r8 = r2 - r1
        {4'd12, 9'd9,  9'd511, 9'd0},  // 8  LRI r9,511
        {4'd8,  9'd7,  9'd20,  9'd0},  // 9  ST r7 -> m[20]
        {4'd7,  9'd10, 9'd20,  9'd0},  // 10 LD r10 <- m[20]
        {4'd4,  9'd1,  9'd8,   9'd1},  // 11 CMP r8,r1 (D=1 must not write)
        {4'd11, 9'd20, 9'd0,   9'd0},  // 12 JZ 20 (not taken)
        {4'd10, 9'd16, 9'd0,   9'd0},  // 13 JN 16 (taken)
        {4'd12, 9'd1,  9'd7,   9'd0},  // 14 flushed
        {4'd12, 9'd1,  9'd8,   9'd0},  // 15 skipped
        {4'd4,  9'd2,  9'd1,   9'd1},  // 16 CMP r1,r1
        {4'd11, 9'd19, 9'd0,   9'd0},  // 17 JZ 19 (taken)
        {4'd12, 9'd2,  9'd9,   9'd0},  // 18 flushed
        {4'd5,  9'd12, 9'd6,   9'd7},  // 19 ADD r12 wraps
        {4'd13, 9'd1,  9'd2,   9'd3},  // 20 no-op code
        {4'd3,  9'd13, 9'd2,   9'd5},  // 21 NOT r13, F2 nonzero
        {4'd9,  9'd22, 9'd0,   9'd0}   // 22 J 22
    };

    // Expected registers: {req number[7:0], reg[8:0], value[15:0]}
    localparam logic [32:0] EXPV [NREG] = '{
        {8'd9,  9'd1,  16'h0064},  // R9 R11 R4: flushed, no-op and CMP left r1
        {8'd9,  9'd2,  16'h0025},  // R9: flushed LRI r2 left no mark
        {8'd12, 9'd3,  16'h0024},  // R12 R2: AND uses r2 written just before
        {8'd2,  9'd4,  16'h0065},  // R2 OR
        {8'd2,  9'd5,  16'h0041},  // R2 XOR
        {8'd3,  9'd6,  16'hFF9B},  // R3 NOT
        {8'd2,  9'd7,  16'h0089},  // R2 ADD
        {8'd2,  9'd8,  16'hFFC1},  // R2 SUB negative
        {8'd7,  9'd9,  16'h01FF},  // R7 zero-extended immediate
        {8'd6,  9'd10, 16'h0089},  // R6 store then load
        {8'd2,  9'd12, 16'h0024},  // R2 wrap on overflow
        {8'd3,  9'd13, 16'hFFDA}   // R3 F2 ignored
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        imem_we = 1'b0;
    logic [8:0]  imem_waddr = '0;
    logic [30:0] imem_wdata = '0;
    logic [8:0]  dbg_reg_addr = '0;
    logic [15:0] dbg_reg_data;
    logic [8:0]  dbg_pc;
    logic        dbg_flag_z;
    logic        dbg_flag_n;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    rcore_top dut_i (
        .clk          (clk),
        .rst          (rst),
        .imem_we      (imem_we),
        .imem_waddr   (imem_waddr),
        .imem_wdata   (imem_wdata),
        .dbg_reg_addr (dbg_reg_addr),
        .dbg_reg_data (dbg_reg_data),
        .dbg_pc       (dbg_pc),
        .dbg_flag_z   (dbg_flag_z),
        .dbg_flag_n   (dbg_flag_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    initial begin
        #20000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: preload instruction memory while reset is held
        for (int i = 0; i < NPROG; i++) begin
            @(negedge clk);
            imem_we    = 1'b1;
            imem_waddr = 9'(i);
            imem_wdata = PROG[i];
        end
        @(negedge clk);
        imem_we = 1'b0;
        @(posedge clk); #1;
        chk("R1 pc in reset", int'(dbg_pc), 0);
        chk("R1 flags in reset", int'({dbg_flag_z, dbg_flag_n}), 0);

        @(negedge clk);
        rst = 1'b0;
        for (int e = 1; e <= 40; e++) begin
            @(posedge clk); #1;
            case (e)
                1:  chk("R1 first fetch pc", int'(dbg_pc), 1);
                12: chk("R5 flags untouched by ALU ops", int'({dbg_flag_z, dbg_flag_n}), 0);
                13: chk("R4 signed compare z,n", int'({dbg_flag_z, dbg_flag_n}), 1);
                14: chk("R10 untaken JZ no bubble pc", int'(dbg_pc), 14);
                15: chk("R8 JN taken pc", int'(dbg_pc), 16);
                16: chk("R8 bubble then fetch pc", int'(dbg_pc), 17);
                17: chk("R4 equal compare z,n", int'({dbg_flag_z, dbg_flag_n}), 2);
                18: chk("R8 JZ taken pc", int'(dbg_pc), 19);
                default: ;
            endcase
        end

        // Register results walked from the vector table
        for (int k = 0; k < NREG; k++) begin
            @(negedge clk);
            dbg_reg_addr = EXPV[k][24:16];
            #1;
            chk($sformatf("R%0d reg %0d", EXPV[k][32:25], EXPV[k][24:16]),
                int'(dbg_reg_data), int'(EXPV[k][15:0]));
        end

        chk("R5 flags after non-compare ops", int'({dbg_flag_z, dbg_flag_n}), 2);
        chk("R8 J self-loop pc range", int'(dbg_pc == 9'd22 || dbg_pc == 9'd23), 1);

        // R1: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        chk("R1 pc after reset", int'(dbg_pc), 0);
        chk("R1 flags after reset", int'({dbg_flag_z, dbg_flag_n}), 0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        chk("R1 restart pc", int'(dbg_pc), 1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule